// File: doc/BRIEF.md
# Memory Request Latency Statistics Unit

This unit watches memory requests as they complete and measures how long each one was in flight. Every completion carries the cycle stamp taken when the request was issued, the memory chip and bank that served it, and a flag marking it as a read. The unit keeps a free-running cycle counter. It takes the latency as the counter value minus the stamp and feeds that latency into several statistics.

The statistics are a histogram of 32 power-of-two buckets, a window sum and a window count, running totals, and a table holding the worst read latency for each chip and bank. A window-close strobe moves the window figures into the totals. An average output gives total latency divided by total count. A combinational read port returns any statistic by address, and a synchronous clear zeroes everything.

Completions arrive on a valid/ready stream. The unit drops ready only while the clear input is high. A completion is accepted in any cycle where valid and ready are both high, and the source must hold its fields while valid is high and ready is low. An input that lowers statistics collection turns every update off, but completions are still accepted.

Top module: `mem_lat_stats`

## Requirements
- R1: The cycle counter is 32 bits wide. It starts at 0 after reset or clear and increases by one every clock, and it can be read at address 37. An accepted completion's latency is the counter value at the accepting edge minus `cmp_ts`, modulo 2^32.
- R2: Each accepted completion with `stat_en` high adds one to the window count (address 32) and adds its latency to the window sum (address 33). The count saturates at 2^CNT_W-1 and the sum saturates at 2^32-1.
- R3: The histogram bucket for a latency is floor(log2(latency)), and a latency of 0 goes to bucket 0. Bucket k is read at address k (0 to 31). Each bucket is CNT_W bits wide and saturates instead of wrapping.
- R4: A `win_close` pulse with `stat_en` high and a nonzero window count adds the window sum to the total sum (address 35) and the window count to the total count (address 34). It then clears the window. A completion accepted in the same cycle becomes the only entry of the new window.
- R5: A `win_close` pulse while the window count is zero or `stat_en` is low changes neither the window nor the totals.
- R6: A read completion (`cmp_is_read`=1) replaces the max-table entry at address 64 + chip*BANKS + bank when its latency is strictly larger. Write completions leave the table unchanged.
- R7: While `stat_en` is low, completions change no histogram, window, total or table entry.
- R8: `avg_valid` is 1 exactly when the total count is nonzero. `avg_lat` is then floor(total sum / total count), and it is 0 otherwise.
- R9: While `clr` is high, `cmp_ready` is 0. The clock edge with `clr` high zeroes every bucket, window value, total, table entry and the cycle counter.
- R10: Addresses with no assigned statistic read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Synchronous clear of all statistics |
| stat_en | input | 1 | Statistics collection enable |
| cmp_valid | input | 1 | Completion present |
| cmp_ready | output | 1 | Completion accepted when high with valid |
| cmp_ts | input | 32 | Issue cycle stamp of the request |
| cmp_chip | input | CHIP_W | Chip that served the request |
| cmp_bank | input | BANK_W | Bank that served the request |
| cmp_is_read | input | 1 | Completion is a read |
| win_close | input | 1 | Close the current window |
| rd_addr | input | 8 | Statistic read address |
| rd_data | output | 32 | Statistic read data |
| avg_valid | output | 1 | Total count is nonzero |
| avg_lat | output | 32 | Average latency over all folded windows |

## Verification
On every cycle, the assertions check that the cycle counter advances by exactly one and that clear empties the window and the totals. They also check that disabled statistics hold the window and the totals steady, that an accepted completion adds one to an unsaturated window count, and that a close adds the old window count into the total. The bench scenarios are needed for the latency arithmetic, the choice of bucket for each latency, saturation, the chip and bank layout of the max table, the difference between reads and writes, the average, and a completion that lands in the closing cycle. Only the scenarios can show those, because each depends on a value computed from the timestamp.

// File: rtl/mls_pkg.sv
package mls_pkg;
  localparam int LAT_W  = 32;
  localparam int NBKT   = 32;
  localparam int BKT_W  = $clog2(NBKT);
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] A_WCNT = 8'd32;
  localparam logic [ADDR_W-1:0] A_WSUM = 8'd33;
  localparam logic [ADDR_W-1:0] A_TCNT = 8'd34;
  localparam logic [ADDR_W-1:0] A_TSUM = 8'd35;
  localparam logic [ADDR_W-1:0] A_CYC  = 8'd37;
  localparam int                MAX_BASE = 64;

  // floor(log2(v)); zero maps to bucket 0
  function automatic logic [BKT_W-1:0] lat_bucket(input logic [LAT_W-1:0] v);
    logic [BKT_W-1:0] b;
    b = '0;
    for (int i = 0; i < LAT_W; i++)
      if (v[i]) b = BKT_W'(i);
    return b;
  endfunction
endpackage

// File: rtl/mls_latency.sv
module mls_latency
  import mls_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [LAT_W-1:0] ts,
  output logic [LAT_W-1:0] cyc,
  output logic [LAT_W-1:0] lat,
  output logic [BKT_W-1:0] bkt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cyc <= '0;
    else if (clr) cyc <= '0;
    else          cyc <= cyc + 1'b1;
  end

  always_comb begin
    lat = cyc - ts;
    bkt = lat_bucket(lat);
  end
endmodule

// File: rtl/mls_hist.sv
module mls_hist
  import mls_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr,
  input  logic                        hit,
  input  logic [BKT_W-1:0]            bkt,
  output logic [NBKT-1:0][CNT_W-1:0]  cnt
);
  for (genvar g = 0; g < NBKT; g++) begin : g_bkt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cnt[g] <= '0;
      else if (clr)
        cnt[g] <= '0;
      else if (hit && bkt == BKT_W'(g) && cnt[g] != '1)
        cnt[g] <= cnt[g] + 1'b1;
    end
  end
endmodule

// File: rtl/mls_maxtab.sv
module mls_maxtab
  import mls_pkg::*;
#(
  parameter int ENT   = 16,
  parameter int IDX_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       upd,
  input  logic [IDX_W-1:0]           idx,
  input  logic [LAT_W-1:0]           lat,
  output logic [ENT-1:0][LAT_W-1:0]  worst
);
  for (genvar g = 0; g < ENT; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        worst[g] <= '0;
      else if (clr)
        worst[g] <= '0;
      else if (upd && idx == IDX_W'(g) && lat > worst[g])
        worst[g] <= lat;
    end
  end
endmodule

// File: rtl/mem_lat_stats.sv
module mem_lat_stats
  import mls_pkg::*;
#(
  parameter int CHIPS = 4,
  parameter int BANKS = 4,
  parameter int CNT_W = 16,
  localparam int CHIP_W = (CHIPS > 1) ? $clog2(CHIPS) : 1,
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              stat_en,
  input  logic              cmp_valid,
  output logic              cmp_ready,
  input  logic [31:0]       cmp_ts,
  input  logic [CHIP_W-1:0] cmp_chip,
  input  logic [BANK_W-1:0] cmp_bank,
  input  logic              cmp_is_read,
  input  logic              win_close,
  input  logic [7:0]        rd_addr,
  output logic [31:0]       rd_data,
  output logic              avg_valid,
  output logic [31:0]       avg_lat
);
  localparam int ENT   = CHIPS * BANKS;
  localparam int IDX_W = (ENT > 1) ? $clog2(ENT) : 1;

  logic [LAT_W-1:0]           cyc_cnt, lat;
  logic [BKT_W-1:0]           bkt;
  logic [NBKT-1:0][CNT_W-1:0] hist;
  logic [ENT-1:0][LAT_W-1:0]  worst;
  logic [CNT_W-1:0]           win_cnt;
  logic [LAT_W-1:0]           win_sum, tot_sum, tot_cnt;
  logic [LAT_W:0]             sum_ext;
  logic [IDX_W-1:0]           ent_idx;
  logic                       acc, fold;

  assign cmp_ready = ~clr;
  assign acc       = cmp_valid & cmp_ready & stat_en;
  assign fold      = stat_en & win_close & (win_cnt != '0);
  assign ent_idx   = IDX_W'(cmp_chip) * IDX_W'(BANKS) + IDX_W'(cmp_bank);
  assign sum_ext   = {1'b0, win_sum} + {1'b0, lat};

  mls_latency u_lat (
    .clk(clk), .rst_n(rst_n), .clr(clr), .ts(cmp_ts),
    .cyc(cyc_cnt), .lat(lat), .bkt(bkt)
  );

  mls_hist #(.CNT_W(CNT_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .clr(clr), .hit(acc), .bkt(bkt), .cnt(hist)
  );

  mls_maxtab #(.ENT(ENT), .IDX_W(IDX_W)) u_max (
    .clk(clk), .rst_n(rst_n), .clr(clr), .upd(acc & cmp_is_read),
    .idx(ent_idx), .lat(lat), .worst(worst)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt <= '0; win_sum <= '0; tot_cnt <= '0; tot_sum <= '0;
    end else if (clr) begin
      win_cnt <= '0; win_sum <= '0; tot_cnt <= '0; tot_sum <= '0;
    end else if (fold) begin
      tot_sum <= tot_sum + win_sum;
      tot_cnt <= tot_cnt + LAT_W'(win_cnt);
      win_cnt <= acc ? CNT_W'(1) : '0;
      win_sum <= acc ? lat : '0;
    end else if (acc) begin
      if (win_cnt != '1) win_cnt <= win_cnt + 1'b1;
      win_sum <= sum_ext[LAT_W] ? '1 : sum_ext[LAT_W-1:0];
    end
  end

  always_comb begin
    logic [7:0] off;
    off     = rd_addr - 8'(MAX_BASE);
    rd_data = '0;
    if (rd_addr < 8'(NBKT))            rd_data = LAT_W'(hist[rd_addr[BKT_W-1:0]]);
    else if (rd_addr == A_WCNT)        rd_data = LAT_W'(win_cnt);
    else if (rd_addr == A_WSUM)        rd_data = win_sum;
    else if (rd_addr == A_TCNT)        rd_data = tot_cnt;
    else if (rd_addr == A_TSUM)        rd_data = tot_sum;
    else if (rd_addr == A_CYC)         rd_data = cyc_cnt;
    else if (rd_addr >= 8'(MAX_BASE) && 32'(off) < ENT)
      rd_data = worst[off[IDX_W-1:0]];
  end

  assign avg_valid = (tot_cnt != '0);
  assign avg_lat   = avg_valid ? tot_sum / tot_cnt : '0;
endmodule

// File: rtl/mls_checker.sv
module mls_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             stat_en,
  input logic             win_close,
  input logic             acc,
  input logic [31:0]      cyc,
  input logic [CNT_W-1:0] win_cnt,
  input logic [31:0]      tot_cnt
);
  // R1
  cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> cyc == $past(cyc) + 32'd1);

  // R9
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (win_cnt == '0 && tot_cnt == '0 && cyc == '0));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_en && !clr) |=> ($stable(win_cnt) && $stable(tot_cnt)));

  // R2
  win_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !win_close && !clr && win_cnt != '1) |=> win_cnt == $past(win_cnt) + 1'b1);

  // R4
  fold_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_en && win_close && !clr && win_cnt != '0)
      |=> tot_cnt == $past(tot_cnt) + 32'($past(win_cnt)));
endmodule

bind mem_lat_stats mls_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .stat_en(stat_en),
  .win_close(win_close), .acc(acc), .cyc(cyc_cnt),
  .win_cnt(win_cnt), .tot_cnt(tot_cnt)
);

// File: tb/mem_lat_stats_tb.sv
module mem_lat_stats_tb;
  localparam int CNT_W = 4;
  localparam int BANKS = 4;

  logic clk = 0, rst_n = 0, clr = 0, stat_en = 0, cmp_valid = 0, cmp_is_read = 0, win_close = 0;
  logic [31:0] cmp_ts = 0;
  logic [1:0]  cmp_chip = 0, cmp_bank = 0;
  logic [7:0]  rd_addr = 0;
  logic        cmp_ready, avg_valid;
  logic [31:0] rd_data, avg_lat;

  int checks = 0, errors = 0;
  logic [31:0] e_hist [32];
  logic [31:0] e_max  [16];
  logic [31:0] e_wcnt, e_wsum, e_tcnt, e_tsum;

  always #5 clk = ~clk;

  mem_lat_stats #(.CHIPS(4), .BANKS(BANKS), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .stat_en(stat_en),
    .cmp_valid(cmp_valid), .cmp_ready(cmp_ready), .cmp_ts(cmp_ts),
    .cmp_chip(cmp_chip), .cmp_bank(cmp_bank), .cmp_is_read(cmp_is_read),
    .win_close(win_close), .rd_addr(rd_addr), .rd_data(rd_data),
    .avg_valid(avg_valid), .avg_lat(avg_lat)
  );

  // {latency[15:0], chip[1:0], bank[1:0], is_read}
  localparam logic [20:0] VEC [0:9] = '{
    {16'd0,     2'd0, 2'd0, 1'b1},
    {16'd1,     2'd0, 2'd1, 1'b1},
    {16'd3,     2'd1, 2'd0, 1'b1},
    {16'd7,     2'd1, 2'd0, 1'b1},
    {16'd8,     2'd1, 2'd0, 1'b1},
    {16'd100,   2'd2, 2'd3, 1'b1},
    {16'd900,   2'd2, 2'd3, 1'b0},
    {16'd1000,  2'd3, 2'd2, 1'b1},
    {16'd65535, 2'd3, 2'd3, 1'b1},
    {16'd5,     2'd3, 2'd3, 1'b1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    rd_addr = a; #1; v = rd_data;
  endtask

  function automatic int bucket(input logic [31:0] v);
    int b = 0;
    for (int i = 0; i < 32; i++) if (v >= (64'd1 << i)) b = i;
    return b;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 32; i++) e_hist[i] = 0;
    for (int i = 0; i < 16; i++) e_max[i] = 0;
    e_wcnt = 0; e_wsum = 0; e_tcnt = 0; e_tsum = 0;
  endtask

  // model update for a completion; called after fold decision
  task automatic model_cmp(input logic [31:0] l, input int c, input int b, input bit r);
    int k;
    k = bucket(l);
    if (e_hist[k] < 15) e_hist[k]++;
    if (e_wcnt < 15) e_wcnt++;
    e_wsum = (64'(e_wsum) + l > 64'hFFFF_FFFF) ? 32'hFFFF_FFFF : e_wsum + l;
    if (r && l > e_max[c*BANKS+b]) e_max[c*BANKS+b] = l;
  endtask

  // one completion, optionally with a window close in the same cycle
  task automatic send(input logic [31:0] l, input int c, input int b, input bit r, input bit cl);
    logic [31:0] cc;
    rd(8'd37, cc);
    cmp_ts = cc - l; cmp_chip = 2'(c); cmp_bank = 2'(b); cmp_is_read = r;
    cmp_valid = 1; win_close = cl;
    @(posedge clk); #1;
    cmp_valid = 0; win_close = 0;
    if (stat_en) begin
      if (cl && e_wcnt != 0) begin
        e_tsum += e_wsum; e_tcnt += e_wcnt; e_wcnt = 0; e_wsum = 0;
      end
      model_cmp(l, c, b, r);
    end
    @(negedge clk);
  endtask

  task automatic close_win();
    win_close = 1;
    @(posedge clk); #1; win_close = 0;
    if (stat_en && e_wcnt != 0) begin
      e_tsum += e_wsum; e_tcnt += e_wcnt; e_wcnt = 0; e_wsum = 0;
    end
    @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    logic [31:0] v;
    for (int i = 0; i < 32; i++) begin rd(8'(i), v); check({tag, " R3 hist"}, v, e_hist[i]); end
    for (int i = 0; i < 16; i++) begin rd(8'(64 + i), v); check({tag, " R6 max"}, v, e_max[i]); end
    rd(8'd32, v); check({tag, " R2 wcnt"}, v, e_wcnt);
    rd(8'd33, v); check({tag, " R2 wsum"}, v, e_wsum);
    rd(8'd34, v); check({tag, " R4 tcnt"}, v, e_tcnt);
    rd(8'd35, v); check({tag, " R4 tsum"}, v, e_tsum);
    check({tag, " R8 avg_valid"}, 32'(avg_valid), 32'(e_tcnt != 0));
    check({tag, " R8 avg_lat"}, avg_lat, (e_tcnt != 0) ? e_tsum / e_tcnt : 0);
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, c0;
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // reset state (R9)
    check_all("reset");
    rd(8'd37, c0); repeat (5) @(posedge clk); @(negedge clk);
    rd(8'd37, v); check("R1 counter step", v, c0 + 5);

    // vector table walk
    stat_en = 1;
    for (int i = 0; i < 10; i++)
      send(32'(VEC[i][20:5]), int'(VEC[i][4:3]), int'(VEC[i][2:1]), VEC[i][0], 1'b0);
    check_all("table");

    // R4 fold and R8 average
    close_win();
    check_all("fold R4");
    // R5 close on empty window
    close_win();
    check_all("empty close R5");
    // R4 completion in closing cycle starts the new window
    send(32'd20, 0, 2, 1'b1, 1'b0);
    send(32'd40, 0, 2, 1'b1, 1'b1);
    check_all("same-cycle R4");
    rd(8'd32, v); check("R4 new window count", v, 32'd1);

    // R7 disabled: completions and close change nothing
    stat_en = 0;
    send(32'd5000, 0, 2, 1'b1, 1'b0);
    close_win();
    check_all("disabled R7");
    rd(8'd66, v); check("R7 max table untouched", v, 32'd40);
    stat_en = 1;

    // R1 latency with wrapped stamp, bucket 31
    send(32'h8000_0005, 1, 1, 1'b1, 1'b0);
    rd(8'd31, v); check("R1 R3 wrap bucket31", v, 32'd1);
    rd(8'd69, v); check("R1 R6 wrap max", v, 32'h8000_0005);

    // R2 R3 saturation
    for (int i = 0; i < 20; i++) send(32'd0, 0, 0, 1'b0, 1'b0);
    check_all("saturate R2 R3");
    rd(8'd0, v); check("R3 bucket0 sat", v, 32'd15);
    // window sum saturation
    send(32'hF000_0000, 1, 2, 1'b0, 1'b0);
    send(32'hF000_0000, 1, 2, 1'b0, 1'b0);
    rd(8'd33, v); check("R2 wsum sat", v, 32'hFFFF_FFFF);

    // R10 unmapped addresses
    rd(8'd36, v); check("R10 unmapped 36", v, 0);
    rd(8'd200, v); check("R10 unmapped 200", v, 0);

    // R9 clear
    clr = 1; #1; check("R9 ready low", 32'(cmp_ready), 0);
    @(posedge clk); #1; clr = 0; model_clear();
    rd(8'd37, v); check("R9 counter cleared", v, 0);
    check_all("clear R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule